// File: doc/BRIEF.md
# Double to Single Rounding Unit

This unit narrows a binary64 operand to the precision and range of binary32 and hands the value back in binary64 form. A later single-precision store of the output is therefore exact, and double-precision code that reads it sees the same value. The unit applies any of four rounding modes and an optional flush-to-zero mode for tiny results. It quietens signalling NaNs and shortens NaN payloads to the binary32 fraction width.

Along with the value it returns the updated floating-point exception flags and a per-operation inexact/rounded pair. It also returns a 5-bit class code for the result. On request it packs four summary bits into a condition nibble. Sticky flags come in on `stat_in` and go out on `stat_out` with this operation's events ORed in. A caller keeps the status word and feeds it back.

Data uses a one-cycle valid strobe with no back-pressure. A new operand may be offered on every cycle and is always taken. The result registers load on the edge that samples `in_valid` high. `out_valid` is high for the following cycle only, and the outputs then hold until the next accepted operand. The consumer must capture a result on its `out_valid` cycle, or before it offers another operand.

Top module: `d2s_round`

## Requirements
- R1: The result is the binary64 encoding of the binary32 value chosen by `in_rmode`: 00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward -infinity. Its 29 low fraction bits are therefore always zero. Zeros, infinities and exactly representable values pass unchanged.
- R2: When the rounded magnitude reaches 2^128 or more, `stat_out` OX and XX are set. The result is a signed infinity under nearest-even and under the directed mode toward the sign. It is the largest finite binary32 magnitude (0x47EFFFFFE0000000 with sign) under toward-zero and under the directed mode away from the sign.
- R3: A nonzero finite input below 2^-126 is tiny. With `in_flush`=1 it returns a zero of the same sign and sets UX and XX. With `in_flush`=0 it is rounded to a binary32 denormal (or the smallest normal), and UX and XX are set when that rounding is inexact.
- R4: A quiet NaN keeps its sign and the top 23 fraction bits, and the lower 29 bits are cleared. A signalling NaN is returned with fraction bit 51 set and raises VX (invalid for signalling NaN).
- R5: When a finite input differs from the result, `out_fi` is 1 and XX is set. `out_fi` reflects the current operation only.
- R6: `out_fr` is 1 exactly when the returned magnitude is larger than the magnitude of the input.
- R7: `out_fprf` classifies the result: +normal 00100, -normal 01000, +denormal 10100, -denormal 11000, +zero 00010, -zero 10010, +infinity 00101, -infinity 01001, NaN 10001.
- R8: With `in_record`=1, `out_cond` is {FX, FEX, VX, OX} from bit 3 down to bit 0, taken after this operation. With `in_record`=0 it is 0000.
- R9: Status layout is {FX, OX, UX, XX, VX} from bit 4 down to bit 0. `stat_out` is the OR of `stat_in` and this operation's events. FX is set only if some event bit goes from 0 to 1; otherwise FX is copied from `stat_in`.
- R10: `out_valid` is high in the cycle after each accepted `in_valid` and low otherwise. All result outputs hold their values while `in_valid` is low. Reset clears every output to zero.
- R11: FEX is the OR of the updated {OX, UX, XX, VX} ANDed with `trap_en` {overflow, underflow, inexact, invalid} from bit 3 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe; taken every cycle it is high |
| in_operand | input | 64 | binary64 operand |
| in_rmode | input | 2 | Rounding mode select |
| in_flush | input | 1 | Flush tiny results to zero |
| in_record | input | 1 | Enable the condition nibble |
| stat_in | input | 5 | Incoming status {FX, OX, UX, XX, VX} |
| trap_en | input | 4 | Exception enables {OX, UX, XX, VX} |
| out_valid | output | 1 | Result strobe, one cycle |
| res_out | output | 64 | Rounded value, binary64 encoding |
| stat_out | output | 5 | Updated status {FX, OX, UX, XX, VX} |
| out_fi | output | 1 | This operation was inexact |
| out_fr | output | 1 | This operation increased the magnitude |
| out_fprf | output | 5 | Result class code |
| out_cond | output | 4 | Condition nibble {FX, FEX, VX, OX} |

## Verification
The sharpest overlap is between rounding and range handling. A round-up can carry out of the mantissa and turn into an overflow, or lift a tiny value to the smallest normal while the underflow flag still has to be raised. The bench provokes both cases with operands one half-ulp below the binary32 limits. It judges them on the exponent in the result, on OX and UX, and on `out_fr`. A second overlap is the summary bit receiving both old and new events in one operation. That case is judged by replaying an overflow with XX and OX already present, then with only XX present.

// File: rtl/d2s_pkg.sv
package d2s_pkg;
  localparam int DBL_W      = 64;
  localparam int DBL_EXP_W  = 11;
  localparam int DBL_FRAC_W = 52;
  localparam int SGL_W      = 32;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_FRAC_W = 23;
  localparam int DBL_BIAS   = (1 << (DBL_EXP_W - 1)) - 1;
  localparam int SGL_BIAS   = (1 << (SGL_EXP_W - 1)) - 1;
  localparam int SGL_EMIN   = 1 - SGL_BIAS;
  localparam int SGL_EXP_MAX = (1 << SGL_EXP_W) - 1;
  localparam int FRAC_DROP  = DBL_FRAC_W - SGL_FRAC_W;
  localparam int EXP_REBIAS = DBL_BIAS - SGL_BIAS;
  localparam int DEN_BASE   = DBL_BIAS + SGL_EMIN - SGL_FRAC_W;
  localparam int STAT_W     = 5;
  localparam int EXC_W      = 4;
  localparam int COND_W     = 4;
  localparam int CLASS_W    = 5;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rmode_e;

  typedef struct packed {
    logic ox;
    logic ux;
    logic xx;
    logic vx;
  } exc_t;

  localparam logic [CLASS_W-1:0] CLS_QNAN  = 5'b10001;
  localparam logic [CLASS_W-1:0] CLS_NINF  = 5'b01001;
  localparam logic [CLASS_W-1:0] CLS_NNORM = 5'b01000;
  localparam logic [CLASS_W-1:0] CLS_NDEN  = 5'b11000;
  localparam logic [CLASS_W-1:0] CLS_NZERO = 5'b10010;
  localparam logic [CLASS_W-1:0] CLS_PZERO = 5'b00010;
  localparam logic [CLASS_W-1:0] CLS_PDEN  = 5'b10100;
  localparam logic [CLASS_W-1:0] CLS_PNORM = 5'b00100;
  localparam logic [CLASS_W-1:0] CLS_PINF  = 5'b00101;
endpackage

// File: rtl/d2s_narrow.sv
module d2s_narrow
  import d2s_pkg::*;
(
  input  logic [DBL_W-1:0] op,
  input  rmode_e           rmode,
  input  logic             flush,
  output logic [SGL_W-1:0] sgl,
  output exc_t             exc,
  output logic             grew
);
  localparam int EW      = DBL_EXP_W + 2;
  localparam int MANT_W  = DBL_FRAC_W + 1;
  localparam int KEEP_W  = SGL_FRAC_W + 1;
  localparam int MAX_SH  = KEEP_W + 3;
  localparam int SH_W    = $clog2(MAX_SH + 1);
  localparam int ALIGN_W = MANT_W + MAX_SH;

  logic                  sgn;
  logic [DBL_EXP_W-1:0]  dexp;
  logic [DBL_FRAC_W-1:0] dfrac;
  logic                  is_nan, is_inf, is_zero, is_sub;
  logic signed [EW-1:0]  unb, def, bexp;
  logic [MANT_W-1:0]     mant;
  logic [SH_W-1:0]       sh;
  logic [ALIGN_W-1:0]    al;
  logic [KEEP_W-1:0]     kept;
  logic                  guard, stk, inexact, inc, tiny, ovf, to_max;
  logic [KEEP_W:0]       rnd;
  logic [SGL_FRAC_W-1:0] nfrac;

  assign {sgn, dexp, dfrac} = op;

  always_comb begin
    is_nan  = (dexp == '1) && (dfrac != '0);
    is_inf  = (dexp == '1) && (dfrac == '0);
    is_zero = (dexp == '0) && (dfrac == '0);
    is_sub  = (dexp == '0);
    unb     = is_sub ? EW'(1 - DBL_BIAS)
                     : $signed({2'b00, dexp}) - EW'(DBL_BIAS);
    mant    = {~is_sub, dfrac};
    tiny    = unb < EW'(SGL_EMIN);
    def     = EW'(SGL_EMIN) - unb;
    if (!tiny)                  sh = '0;
    else if (def > EW'(MAX_SH)) sh = SH_W'(MAX_SH);
    else                        sh = def[SH_W-1:0];
    al      = {mant, {MAX_SH{1'b0}}} >> sh;
    kept    = al[ALIGN_W-1 -: KEEP_W];
    guard   = al[ALIGN_W-KEEP_W-1];
    stk     = |al[ALIGN_W-KEEP_W-2:0];
    inexact = guard | stk;
    unique case (rmode)
      RM_NEAR: inc = guard & (stk | kept[0]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = inexact & ~sgn;
      RM_DOWN: inc = inexact & sgn;
      default: inc = 1'b0;
    endcase
    rnd     = {1'b0, kept} + {{KEEP_W{1'b0}}, inc};
    bexp    = unb + EW'(SGL_BIAS) + (rnd[KEEP_W] ? EW'(1) : EW'(0));
    nfrac   = rnd[KEEP_W] ? '0 : rnd[SGL_FRAC_W-1:0];
    ovf     = !tiny && (bexp >= EW'(SGL_EXP_MAX));
    to_max  = (rmode == RM_ZERO) || (rmode == RM_UP && sgn) ||
              (rmode == RM_DOWN && !sgn);
  end

  always_comb begin
    sgl  = '0;
    exc  = '0;
    grew = 1'b0;
    if (is_nan) begin
      sgl    = {sgn, {SGL_EXP_W{1'b1}}, 1'b1,
                dfrac[DBL_FRAC_W-2 -: SGL_FRAC_W-1]};
      exc.vx = ~dfrac[DBL_FRAC_W-1];
    end else if (is_inf) begin
      sgl = {sgn, {SGL_EXP_W{1'b1}}, {SGL_FRAC_W{1'b0}}};
    end else if (is_zero) begin
      sgl = {sgn, {(SGL_W-1){1'b0}}};
    end else if (tiny && flush) begin
      sgl    = {sgn, {(SGL_W-1){1'b0}}};
      exc.ux = 1'b1;
      exc.xx = 1'b1;
    end else if (ovf) begin
      exc.ox = 1'b1;
      exc.xx = 1'b1;
      if (to_max) begin
        sgl = {sgn, {(SGL_EXP_W-1){1'b1}}, 1'b0, {SGL_FRAC_W{1'b1}}};
      end else begin
        sgl  = {sgn, {SGL_EXP_W{1'b1}}, {SGL_FRAC_W{1'b0}}};
        grew = 1'b1;
      end
    end else if (tiny) begin
      sgl    = {sgn, {(SGL_EXP_W-1){1'b0}}, rnd[SGL_FRAC_W],
                rnd[SGL_FRAC_W-1:0]};
      exc.xx = inexact;
      exc.ux = inexact;
      grew   = inc;
    end else begin
      sgl    = {sgn, bexp[SGL_EXP_W-1:0], nfrac};
      exc.xx = inexact;
      grew   = inc;
    end
  end
endmodule

// File: rtl/d2s_widen.sv
module d2s_widen
  import d2s_pkg::*;
(
  input  logic [SGL_W-1:0]   sgl,
  output logic [DBL_W-1:0]   dbl,
  output logic [CLASS_W-1:0] cls
);
  localparam int LZ_W = $clog2(SGL_FRAC_W + 1);

  logic                  s;
  logic [SGL_EXP_W-1:0]  e;
  logic [SGL_FRAC_W-1:0] f, nf;
  logic [LZ_W-1:0]       lead;

  assign {s, e, f} = sgl;

  always_comb begin
    lead = '0;
    for (int i = 0; i < SGL_FRAC_W; i++) begin
      if (f[i]) lead = LZ_W'(i);
    end
    nf = f << (LZ_W'(SGL_FRAC_W) - lead);
  end

  always_comb begin
    if (e == '1) begin
      if (f != '0) begin
        dbl = {s, {DBL_EXP_W{1'b1}}, f, {FRAC_DROP{1'b0}}};
        cls = CLS_QNAN;
      end else begin
        dbl = {s, {DBL_EXP_W{1'b1}}, {DBL_FRAC_W{1'b0}}};
        cls = s ? CLS_NINF : CLS_PINF;
      end
    end else if (e == '0) begin
      if (f == '0) begin
        dbl = {s, {(DBL_W-1){1'b0}}};
        cls = s ? CLS_NZERO : CLS_PZERO;
      end else begin
        dbl = {s, DBL_EXP_W'(DEN_BASE) + {{(DBL_EXP_W-LZ_W){1'b0}}, lead},
               nf, {FRAC_DROP{1'b0}}};
        cls = s ? CLS_NDEN : CLS_PDEN;
      end
    end else begin
      dbl = {s, {{(DBL_EXP_W-SGL_EXP_W){1'b0}}, e} + DBL_EXP_W'(EXP_REBIAS),
             f, {FRAC_DROP{1'b0}}};
      cls = s ? CLS_NNORM : CLS_PNORM;
    end
  end
endmodule

// File: rtl/d2s_status.sv
module d2s_status
  import d2s_pkg::*;
(
  input  logic [STAT_W-1:0] stat_in,
  input  exc_t              exc,
  input  logic [EXC_W-1:0]  trap_en,
  input  logic              record,
  output logic [STAT_W-1:0] stat_out,
  output logic [COND_W-1:0] cond
);
  logic [EXC_W-1:0] old_ev, new_ev;
  logic             fx, fex;

  always_comb begin
    old_ev   = stat_in[EXC_W-1:0];
    new_ev   = old_ev | exc;
    fx       = stat_in[STAT_W-1] | (|(exc & ~old_ev));
    fex      = |(new_ev & trap_en);
    stat_out = {fx, new_ev};
    cond     = record ? {fx, fex, new_ev[0], new_ev[EXC_W-1]} : '0;
  end
endmodule

// File: rtl/d2s_round.sv
module d2s_round
  import d2s_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [DBL_W-1:0]     in_operand,
  input  logic [1:0]           in_rmode,
  input  logic                 in_flush,
  input  logic                 in_record,
  input  logic [STAT_W-1:0]    stat_in,
  input  logic [EXC_W-1:0]     trap_en,
  output logic                 out_valid,
  output logic [DBL_W-1:0]     res_out,
  output logic [STAT_W-1:0]    stat_out,
  output logic                 out_fi,
  output logic                 out_fr,
  output logic [CLASS_W-1:0]   out_fprf,
  output logic [COND_W-1:0]    out_cond
);
  logic [SGL_W-1:0]   sgl;
  exc_t               exc;
  logic               grew;
  logic [DBL_W-1:0]   wide;
  logic [CLASS_W-1:0] cls;
  logic [STAT_W-1:0]  st_nx;
  logic [COND_W-1:0]  cond_nx;

  d2s_narrow u_narrow (
    .op    (in_operand),
    .rmode (rmode_e'(in_rmode)),
    .flush (in_flush),
    .sgl   (sgl),
    .exc   (exc),
    .grew  (grew)
  );

  d2s_widen u_widen (
    .sgl (sgl),
    .dbl (wide),
    .cls (cls)
  );

  d2s_status u_status (
    .stat_in  (stat_in),
    .exc      (exc),
    .trap_en  (trap_en),
    .record   (in_record),
    .stat_out (st_nx),
    .cond     (cond_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_out   <= '0;
      stat_out  <= '0;
      out_fi    <= 1'b0;
      out_fr    <= 1'b0;
      out_fprf  <= '0;
      out_cond  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_out  <= wide;
        stat_out <= st_nx;
        out_fi   <= exc.xx;
        out_fr   <= grew;
        out_fprf <= cls;
        out_cond <= cond_nx;
      end
    end
  end
endmodule

// File: rtl/d2s_round_chk.sv
module d2s_round_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] in_operand,
  input logic        in_record,
  input logic [4:0]  stat_in,
  input logic        out_valid,
  input logic [63:0] res_out,
  input logic [4:0]  stat_out,
  input logic        out_fi,
  input logic        out_fr,
  input logic [3:0]  out_cond
);
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r10_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res_out));
  a_r1_single_grid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (res_out[28:0] == 29'd0));
  a_r4_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && res_out[62:52] == 11'h7ff && res_out[51:0] != 52'd0)
      |-> res_out[51]);
  a_r4_snan_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_operand[62:52] == 11'h7ff && !in_operand[51] &&
     in_operand[50:0] != 51'd0) |=> stat_out[0]);
  a_r9_sticky_keep: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((stat_out & $past(stat_in)) == $past(stat_in)));
  a_r6_fr_needs_fi: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fr) |-> out_fi);
  a_r8_cond_off: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_record) |=> (out_cond == 4'd0));
endmodule

bind d2s_round d2s_round_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_operand (in_operand),
  .in_record  (in_record),
  .stat_in    (stat_in),
  .out_valid  (out_valid),
  .res_out    (res_out),
  .stat_out   (stat_out),
  .out_fi     (out_fi),
  .out_fr     (out_fr),
  .out_cond   (out_cond)
);

// File: tb/d2s_round_test.sv
`timescale 1ns/1ps
module d2s_round_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_operand = '0;
  logic [1:0]  in_rmode = '0;
  logic        in_flush = 1'b0;
  logic        in_record = 1'b0;
  logic [4:0]  stat_in = '0;
  logic [3:0]  trap_en = '0;
  logic        out_valid;
  logic [63:0] res_out;
  logic [4:0]  stat_out;
  logic        out_fi, out_fr;
  logic [4:0]  out_fprf;
  logic [3:0]  out_cond;
  int          checks = 0;
  int          fails = 0;

  always #10 clk = ~clk;

  d2s_round uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
    .in_rmode(in_rmode), .in_flush(in_flush), .in_record(in_record),
    .stat_in(stat_in), .trap_en(trap_en), .out_valid(out_valid),
    .res_out(res_out), .stat_out(stat_out), .out_fi(out_fi), .out_fr(out_fr),
    .out_fprf(out_fprf), .out_cond(out_cond)
  );

  // operand, mode, flush, result, {OX,UX,XX,VX}, fi, fr, class
  localparam int NV = 30;
  localparam logic [141:0] VEC [NV] = '{
    {64'h3FF0000000000000, 2'b00, 1'b0, 64'h3FF0000000000000, 4'b0000, 1'b0, 1'b0, 5'b00100}, // R1 exact
    {64'hC004000000000000, 2'b00, 1'b0, 64'hC004000000000000, 4'b0000, 1'b0, 1'b0, 5'b01000},
    {64'h3FF0000010000000, 2'b00, 1'b0, 64'h3FF0000000000000, 4'b0010, 1'b1, 1'b0, 5'b00100}, // tie to even
    {64'h3FF0000010000000, 2'b10, 1'b0, 64'h3FF0000020000000, 4'b0010, 1'b1, 1'b1, 5'b00100},
    {64'h3FF0000010000001, 2'b00, 1'b0, 64'h3FF0000020000000, 4'b0010, 1'b1, 1'b1, 5'b00100},
    {64'h3FF0000030000000, 2'b00, 1'b0, 64'h3FF0000040000000, 4'b0010, 1'b1, 1'b1, 5'b00100},
    {64'hBFF0000010000001, 2'b11, 1'b0, 64'hBFF0000020000000, 4'b0010, 1'b1, 1'b1, 5'b01000},
    {64'hBFF0000010000001, 2'b01, 1'b0, 64'hBFF0000000000000, 4'b0010, 1'b1, 1'b0, 5'b01000},
    {64'hBFF0000010000001, 2'b10, 1'b0, 64'hBFF0000000000000, 4'b0010, 1'b1, 1'b0, 5'b01000},
    {64'h3FFFFFFFF0000000, 2'b00, 1'b0, 64'h4000000000000000, 4'b0010, 1'b1, 1'b1, 5'b00100}, // carry
    {64'h47F0000000000000, 2'b00, 1'b0, 64'h7FF0000000000000, 4'b1010, 1'b1, 1'b1, 5'b00101}, // R2
    {64'h47F0000000000000, 2'b01, 1'b0, 64'h47EFFFFFE0000000, 4'b1010, 1'b1, 1'b0, 5'b00100}, // R2
    {64'hC7F0000000000000, 2'b10, 1'b0, 64'hC7EFFFFFE0000000, 4'b1010, 1'b1, 1'b0, 5'b01000}, // R2
    {64'hC7F0000000000000, 2'b11, 1'b0, 64'hFFF0000000000000, 4'b1010, 1'b1, 1'b1, 5'b01001}, // R2
    {64'h47EFFFFFF0000000, 2'b00, 1'b0, 64'h7FF0000000000000, 4'b1010, 1'b1, 1'b1, 5'b00101}, // R2 via carry
    {64'h36A0000000000000, 2'b00, 1'b0, 64'h36A0000000000000, 4'b0000, 1'b0, 1'b0, 5'b10100}, // R3 exact tiny
    {64'h36A0000000000000, 2'b00, 1'b1, 64'h0000000000000000, 4'b0110, 1'b1, 1'b0, 5'b00010}, // R3 flush
    {64'h3690000000000000, 2'b00, 1'b0, 64'h0000000000000000, 4'b0110, 1'b1, 1'b0, 5'b00010}, // R3
    {64'h3690000000000000, 2'b10, 1'b0, 64'h36A0000000000000, 4'b0110, 1'b1, 1'b1, 5'b10100}, // R3
    {64'h36B8000000000000, 2'b00, 1'b0, 64'h36B8000000000000, 4'b0000, 1'b0, 1'b0, 5'b10100}, // R3
    {64'h380FFFFFFFFFFFFF, 2'b00, 1'b0, 64'h3810000000000000, 4'b0110, 1'b1, 1'b1, 5'b00100}, // R3 to normal
    {64'h0000000000000001, 2'b00, 1'b0, 64'h0000000000000000, 4'b0110, 1'b1, 1'b0, 5'b00010}, // R3
    {64'h8000000000000001, 2'b11, 1'b0, 64'hB6A0000000000000, 4'b0110, 1'b1, 1'b1, 5'b11000}, // R3
    {64'h8000000000000000, 2'b00, 1'b0, 64'h8000000000000000, 4'b0000, 1'b0, 1'b0, 5'b10010},
    {64'h7FF0000000000000, 2'b00, 1'b0, 64'h7FF0000000000000, 4'b0000, 1'b0, 1'b0, 5'b00101},
    {64'h7FFC0000F0000000, 2'b00, 1'b0, 64'h7FFC0000E0000000, 4'b0000, 1'b0, 1'b0, 5'b10001}, // R4 qnan
    {64'hFFF4000000000000, 2'b00, 1'b0, 64'hFFFC000000000000, 4'b0001, 1'b0, 1'b0, 5'b10001}, // R4 snan
    {64'h7FF0000000000001, 2'b00, 1'b0, 64'h7FF8000000000000, 4'b0001, 1'b0, 1'b0, 5'b10001}, // R4 snan
    {64'h3FF0000010000000, 2'b01, 1'b1, 64'h3FF0000000000000, 4'b0010, 1'b1, 1'b0, 5'b00100},
    {64'h47EFFFFFE0000000, 2'b00, 1'b0, 64'h47EFFFFFE0000000, 4'b0000, 1'b0, 1'b0, 5'b00100}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] op, input logic [1:0] rm, input logic fl,
                       input logic rec, input logic [4:0] st, input logic [3:0] en);
    @(negedge clk);
    in_operand = op; in_rmode = rm; in_flush = fl; in_record = rec;
    stat_in = st; trap_en = en; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    check("R10 reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R10 reset result", res_out, 64'd0);
    check("R10 reset cond", {60'd0, out_cond}, 64'd0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [141:0] v;
      logic [3:0]   ev;
      v  = VEC[k];
      ev = v[10:7];
      apply(v[141:78], v[77:76], v[75], 1'b1, 5'd0, 4'd0);
      check($sformatf("R10 valid vec %0d", k), {63'd0, out_valid}, 64'd1);
      check($sformatf("R1 result vec %0d", k), res_out, v[74:11]);
      check($sformatf("R9 status vec %0d", k), {59'd0, stat_out}, {59'd0, |ev, ev});
      check($sformatf("R5 fi vec %0d", k), {63'd0, out_fi}, {63'd0, v[6]});
      check($sformatf("R6 fr vec %0d", k), {63'd0, out_fr}, {63'd0, v[5]});
      check($sformatf("R7 class vec %0d", k), {59'd0, out_fprf}, {59'd0, v[4:0]});
      check($sformatf("R8 cond vec %0d", k), {60'd0, out_cond}, {60'd0, |ev, 1'b0, ev[0], ev[3]});
    end

    // R10: outputs hold while no operand is offered
    held = res_out;
    @(negedge clk);
    check("R10 valid low", {63'd0, out_valid}, 64'd0);
    in_operand = 64'h3FF0000000000000;
    repeat (3) @(negedge clk);
    check("R10 hold result", res_out, held);

    // R9: no new event keeps FX clear
    apply(64'h47F0000000000000, 2'b00, 1'b0, 1'b1, 5'b01010, 4'd0);
    check("R9 no new event", {59'd0, stat_out}, {59'd0, 5'b01010});
    apply(64'h47F0000000000000, 2'b00, 1'b0, 1'b1, 5'b00010, 4'd0);
    check("R9 new overflow", {59'd0, stat_out}, {59'd0, 5'b11010});
    apply(64'h3FF0000000000000, 2'b00, 1'b0, 1'b1, 5'b10001, 4'd0);
    check("R9 sticky kept", {59'd0, stat_out}, {59'd0, 5'b10001});
    check("R5 fi clears on exact", {63'd0, out_fi}, 64'd0);

    // R11: enabled-exception summary
    apply(64'h3FF0000010000000, 2'b00, 1'b0, 1'b1, 5'd0, 4'b0010);
    check("R11 inexact enabled", {60'd0, out_cond}, {60'd0, 4'b1100});
    apply(64'h3FF0000010000000, 2'b00, 1'b0, 1'b1, 5'd0, 4'b0001);
    check("R11 inexact not enabled", {60'd0, out_cond}, {60'd0, 4'b1000});
    apply(64'h3FF0000000000000, 2'b00, 1'b0, 1'b1, 5'b00001, 4'b0001);
    check("R11 old invalid enabled", {60'd0, out_cond}, {60'd0, 4'b0110});

    // R8: record disabled
    apply(64'hFFF4000000000000, 2'b00, 1'b0, 1'b0, 5'd0, 4'b1111);
    check("R8 cond off", {60'd0, out_cond}, 64'd0);
    check("R4 snan without record", {59'd0, stat_out}, {59'd0, 5'b10001});

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule